// File: doc/BRIEF.md
# I2C Configuration Register Target

This block is an I2C target that lets a bus master read and write a bank of byte-wide configuration registers inside a chip. Each chip answers its own 7-bit device address. It also answers the broadcast general-call address 0x00 for writes, so a single frame can load the same setting into every chip that shares the bus. All register contents are presented in parallel on `cfg_out` and drive the rest of the chip.

A write frame is START, the device address with the R/W bit at 0, the register pointer byte and one data byte, then STOP. Each byte is followed by an acknowledge from the target. A read frame first sets the pointer in the same way. A repeated START follows, then the device address with the R/W bit at 1. The target then shifts out one register byte, MSB first, and the master answers it with ACK or NACK. A read only copies the addressed register, so readback never changes the stored configuration.

The master drives SCL and the target never stretches it. SDA is open-drain: the block only asserts `sda_oe` to pull the line low. Both bus lines pass through a two-flop synchronizer. START and STOP are recognised as SDA edges while SCL is high, and either one ends whatever transfer is in progress.

Top module: `i2c_cfg_port`

## Requirements
- R1: During and after reset, `sda_oe` is 0 and every register holds RESET_VAL (0x00 by default).
- R2: A write frame to DEV_ADDR gets an ACK on the address byte, the pointer byte and the data byte. The data byte then appears on `cfg_out[8*p+7:8*p]`, where p is the pointer value.
- R3: A write frame to the general-call address 0x00 is acknowledged and writes the register in the same way as R2.
- R4: An address byte whose upper 7 bits are neither DEV_ADDR nor 0x00 gets no ACK. The bytes that follow get no ACK and no register changes.
- R5: A read frame (pointer write, repeated START, DEV_ADDR with R/W = 1) returns the addressed register MSB first. After the master's ACK or NACK bit the target releases SDA.
- R6: A read leaves every bit of `cfg_out` unchanged.
- R7: A general-call address byte with R/W = 1 gets no ACK, and the target does not drive SDA for the rest of that frame.
- R8: A pointer of NREGS or more is acknowledged. A data byte written there changes no register, and a read from there returns 0x00.
- R9: A STOP or a START received in the middle of a byte aborts the transfer: a partly received data byte is not written, and the next frame is handled normally.
- R10: `sda_oe` changes only while SCL is low.
- R11: A second data byte after the first one in a write frame is not acknowledged and not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_out | output | NREGS*8 | All configuration registers, register i in bits [8i+7:8i] |

## Verification
The bench builds the block with NREGS = 4 and DEV_ADDR = 0x2A. With only four registers, any pointer from 4 to 255 reaches the out-of-range path of R8 without a large bank. Address 0x11 is a foreign address for R4, and general-call frames are tried in both directions. A behavioural model of the register file and of the acknowledge rules is compared against `cfg_out` on every clock. The same per-clock monitor checks that `sda_oe` only changes while SCL is low.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK, ST_SKIP
  } port_state_t;

  localparam logic [6:0] GCALL_ADDR = 7'h00;

  // own address in both directions, broadcast only for writes
  function automatic logic addr_accept(input logic [6:0] a, input logic rw,
                                       input logic [6:0] own);
    return (a == own) || ((a == GCALL_ADDR) && !rw);
  endfunction

  function automatic logic ptr_in_range(input logic [7:0] p, input int unsigned n);
    return {24'd0, p} < n;
  endfunction

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_m, sda_m, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1; sda_m <= 1'b1;
      scl_s <= 1'b1; sda_s <= 1'b1;
      scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_m <= scl_in; sda_m <= sda_in;
      scl_s <= scl_m;  sda_s <= sda_m;
      scl_q <= scl_s;  sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import i2c_cfg_pkg::*;
#(
  parameter int NREGS = 16,
  parameter logic [7:0] RESET_VAL = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_ptr,
  input  logic [7:0]       wr_data,
  input  logic [7:0]       rd_ptr,
  output logic [7:0]       rd_data,
  output logic [NREGS*8-1:0] cfg_flat
);
  logic [7:0] regs [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[i] <= RESET_VAL;
      else if (wr_en && (wr_ptr == 8'(i)))
        regs[i] <= wr_data;
    end
    assign cfg_flat[i*8 +: 8] = regs[i];
  end

  // pointers with no register read as zero
  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREGS; i++)
      if (rd_ptr == 8'(i)) rd_data = regs[i];
  end

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_flat));

  // R8
  oob_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ptr_in_range(wr_ptr, NREGS)) |=> $stable(cfg_flat));

endmodule

// File: rtl/i2c_cfg_port.sv
module i2c_cfg_port
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int NREGS = 16,
  parameter logic [7:0] RESET_VAL = 8'h00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  output logic [NREGS*8-1:0] cfg_out
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  port_state_t state;
  logic [3:0]  bit_cnt;
  logic [7:0]  shreg, txbyte, ptr, rd_data;
  logic        is_read, oe_q;

  i2c_bus_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  wire byte_done = scl_fall && (bit_cnt == 4'd8);
  wire addr_done = (state == ST_ADDR) && byte_done;
  wire wr_en     = (state == ST_WDATA) && byte_done;

  cfg_regbank #(.NREGS(NREGS), .RESET_VAL(RESET_VAL)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(ptr), .wr_data(shreg),
    .rd_ptr(ptr), .rd_data(rd_data), .cfg_flat(cfg_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; bit_cnt <= '0; shreg <= '0; txbyte <= '0;
      ptr <= '0; is_read <= 1'b0; oe_q <= 1'b0;
    end else if (start_evt) begin
      state <= ST_ADDR; bit_cnt <= '0; oe_q <= 1'b0;
    end else if (stop_evt) begin
      state <= ST_IDLE; oe_q <= 1'b0;
    end else begin
      if (scl_rise) begin
        shreg <= {shreg[6:0], sda_s};
        if (bit_cnt != 4'd8) bit_cnt <= bit_cnt + 4'd1;
      end
      if (scl_fall) begin
        case (state)
          ST_ADDR: if (byte_done) begin
            bit_cnt <= '0;
            if (addr_accept(shreg[7:1], shreg[0], DEV_ADDR)) begin
              state <= ST_ADDR_ACK; oe_q <= 1'b1; is_read <= shreg[0];
            end else
              state <= ST_SKIP;
          end
          ST_ADDR_ACK: begin
            bit_cnt <= '0;
            if (is_read) begin
              state <= ST_RDATA; oe_q <= ~rd_data[7]; txbyte <= {rd_data[6:0], 1'b0};
            end else begin
              state <= ST_PTR; oe_q <= 1'b0;
            end
          end
          ST_PTR: if (byte_done) begin
            ptr <= shreg; state <= ST_PTR_ACK; oe_q <= 1'b1; bit_cnt <= '0;
          end
          ST_PTR_ACK: begin
            state <= ST_WDATA; oe_q <= 1'b0; bit_cnt <= '0;
          end
          ST_WDATA: if (byte_done) begin
            state <= ST_WDATA_ACK; oe_q <= 1'b1; bit_cnt <= '0;
          end
          ST_WDATA_ACK: begin
            state <= ST_SKIP; oe_q <= 1'b0;
          end
          ST_RDATA: begin
            if (bit_cnt == 4'd8) begin
              state <= ST_RACK; oe_q <= 1'b0; bit_cnt <= '0;
            end else begin
              oe_q <= ~txbyte[7]; txbyte <= {txbyte[6:0], 1'b0};
            end
          end
          ST_RACK: begin
            state <= ST_SKIP; oe_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe = oe_q;

  // R10
  oe_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R9
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |=> !sda_oe);

  // R7
  gcall_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && shreg[7:1] == GCALL_ADDR && shreg[0]) |=> !sda_oe);

  // R4
  foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && shreg[7:1] != DEV_ADDR && shreg[7:1] != GCALL_ADDR)
      |=> (state == ST_SKIP && !sda_oe));

  // R11
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |=> !sda_oe);

endmodule

// File: tb/i2c_cfg_port_test.sv
module i2c_cfg_port_test;
  localparam int NR = 4;
  localparam logic [6:0] DEV = 7'h2A;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NR*8-1:0] cfg_out;
  wire sda_bus = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  i2c_cfg_port #(.DEV_ADDR(DEV), .NREGS(NR), .RESET_VAL(8'h00)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_bus),
    .sda_oe(sda_oe), .cfg_out(cfg_out)
  );

  int n_chk = 0, n_fail = 0, cfg_mism = 0, oe_viol = 0;
  bit done = 0, cmp_en = 0, pend_wr = 0;
  int pend_idx;
  logic [7:0] pend_val;
  logic [7:0] model [NR];
  logic prev_oe = 1'b0;

  function automatic logic [NR*8-1:0] model_flat();
    logic [NR*8-1:0] f;
    for (int i = 0; i < NR; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  function automatic bit accepts(input logic [6:0] a, input logic rw);
    if (a == DEV) return 1;
    return (a == 7'h00) && (rw == 1'b0);
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmp_en && cfg_out !== model_flat()) cfg_mism++;
      if (sda_oe !== prev_oe && scl_drv) oe_viol++;
      prev_oe = sda_oe;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q);
    scl_drv = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_drv = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q);
    scl_drv = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q);
    scl_drv = 1'b1; tick(2*Q);
    scl_drv = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_drv = 1'b1; tick(2*Q);
      if (i == 0 && pend_wr) cmp_en = 0;
      scl_drv = 1'b0; tick(Q);
      if (i == 0 && pend_wr) begin
        model[pend_idx] = pend_val; pend_wr = 0; cmp_en = 1;
      end
    end
    sda_m = 1'b1; tick(Q);
    scl_drv = 1'b1; tick(Q);
    ack = ~sda_bus; tick(Q);
    scl_drv = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q);
      scl_drv = 1'b1; tick(Q);
      d[i] = sda_bus; tick(Q);
      scl_drv = 1'b0; tick(Q);
    end
    sda_m = ~mack; tick(Q);
    scl_drv = 1'b1; tick(2*Q);
    scl_drv = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] p, input logic [7:0] v,
                        output logic [2:0] acks);
    logic k0, k1, k2;
    i2c_start();
    send_byte({a, 1'b0}, k0);
    send_byte(p, k1);
    if (accepts(a, 1'b0) && p < NR) begin
      pend_wr = 1; pend_idx = int'(p); pend_val = v;
    end
    send_byte(v, k2);
    i2c_stop();
    acks = {k0, k1, k2};
  endtask

  task automatic rd_txn(input logic [6:0] a, input logic [7:0] p, input logic mack,
                        output logic [2:0] acks, output logic [7:0] d);
    logic k0, k1, k2;
    i2c_start();
    send_byte({a, 1'b0}, k0);
    send_byte(p, k1);
    i2c_start();
    send_byte({a, 1'b1}, k2);
    recv_byte(mack, d);
    i2c_stop();
    acks = {k0, k1, k2};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [2:0] acks;
    logic [7:0] d;
    logic k;
    logic [NR*8-1:0] snap;
    for (int i = 0; i < NR; i++) model[i] = 8'h00;
    tick(5);
    // R1 reset state
    chk("R1 oe", {31'd0, sda_oe}, 32'd0);
    chk("R1 cfg", cfg_out, 32'd0);
    rst_n = 1'b1; tick(5);
    cmp_en = 1;

    // R2 own-address write
    wr_txn(DEV, 8'd2, 8'hA5, acks);
    chk("R2 acks", {29'd0, acks}, 32'd7);
    chk("R2 reg2", {24'd0, cfg_out[23:16]}, 32'hA5);

    // R5 / R6 read with master NACK
    snap = cfg_out;
    rd_txn(DEV, 8'd2, 1'b0, acks, d);
    chk("R5 acks", {29'd0, acks}, 32'd7);
    chk("R5 data", {24'd0, d}, 32'hA5);
    chk("R5 release", {31'd0, sda_oe}, 32'd0);
    chk("R6 unchanged", cfg_out, snap);

    // R3 general-call write
    wr_txn(7'h00, 8'd1, 8'h3C, acks);
    chk("R3 acks", {29'd0, acks}, 32'd7);
    chk("R3 reg1", {24'd0, cfg_out[15:8]}, 32'h3C);

    // R4 foreign address
    snap = cfg_out;
    wr_txn(7'h11, 8'd0, 8'h99, acks);
    chk("R4 acks", {29'd0, acks}, 32'd0);
    chk("R4 unchanged", cfg_out, snap);

    // R7 general-call read
    i2c_start();
    send_byte({7'h00, 1'b1}, k);
    chk("R7 nack", {31'd0, k}, 32'd0);
    recv_byte(1'b0, d);
    chk("R7 bus idle", {24'd0, d}, 32'hFF);
    i2c_stop();

    // R8 out-of-range pointer
    snap = cfg_out;
    wr_txn(DEV, 8'd9, 8'h5A, acks);
    chk("R8 acks", {29'd0, acks}, 32'd7);
    chk("R8 dropped", cfg_out, snap);
    rd_txn(DEV, 8'd9, 1'b0, acks, d);
    chk("R8 read zero", {24'd0, d}, 32'h00);

    // R9 STOP in the middle of a data byte
    i2c_start();
    send_byte({DEV, 1'b0}, k);
    send_byte(8'd3, k);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    i2c_stop();
    chk("R9 no partial write", {24'd0, cfg_out[31:24]}, 32'h00);
    wr_txn(DEV, 8'd3, 8'h77, acks);
    chk("R9 recovered", {21'd0, acks, cfg_out[31:24]}, {21'd0, 3'd7, 8'h77});

    // R11 extra data byte
    i2c_start();
    send_byte({DEV, 1'b0}, k);
    send_byte(8'd0, k);
    pend_wr = 1; pend_idx = 0; pend_val = 8'h11;
    send_byte(8'h11, k);
    send_byte(8'h22, k);
    chk("R11 nack", {31'd0, k}, 32'd0);
    i2c_stop();
    chk("R11 reg0", {24'd0, cfg_out[7:0]}, 32'h11);

    // R5 read with master ACK
    rd_txn(DEV, 8'd1, 1'b1, acks, d);
    chk("R5 mack data", {24'd0, d}, 32'h3C);

    // R2 per-clock model comparison, R10 SDA timing
    chk("R2 cfg per clock", cfg_mism, 0);
    chk("R10 oe while scl high", oe_viol, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule